// File: doc/BRIEF.md
# DMA Channel Count and Address Sequencer

This block is the bookkeeping core of a single DMA channel. The transfer engine sends one `step_i` pulse for each byte or word it has moved. On that pulse the block lowers the 16-bit current count by one. It advances the 32-bit current address and captures the moved data into a 16-bit temporary register. It also decides whether the channel stops.

Three things can stop the channel:
- a count underflow, which raises terminal count;
- an external end-of-transfer request;
- in demand mode, the request line going quiet.

The results appear as registered pulses in the cycle after the step: an end indication, an acknowledge, and strobes that clear the request bits held elsewhere.

Software starts the channel by loading the count. It may load the address on its own. Once stopped, the channel stays idle until the next count load. Bus cycles and arbitration between channels are handled outside this block.

Top module: `dmaseq_chan`

## Requirements
- R1: After reset the following all read zero: count, address, temporary register, active, terminal count and every pulse output.
- R2: Each step while active lowers the count by exactly one. Transfer type is taken from `mode_i[7:6]`: 00 demand, 01 single, 10 block, 11 treated as block. In block mode the channel stays active until underflow or an end request.
- R3: A step taken when the count is 0x0000 makes it 0xFFFF. In the following cycle `tc_o` is set and `done_o` and `ack_o` pulse for one cycle. `active_o` drops in that same cycle.
- R4: In any mode except single, a step with `end_req_i` high ends the channel: `done_o` and `ack_o` pulse and `tc_o` stays low. `ack_o` never pulses without `done_o`.
- R5: In demand mode, a step with `dreq_i` low ends the channel. `done_o` pulses, while `ack_o` and `tc_o` stay low. A step with `dreq_i` high keeps the channel active.
- R6: In single mode every step pulses `clr_req_o` and `clr_sreq_o` for one cycle, including the step that reaches terminal count. `end_req_i` has no effect in single mode. In any other mode these strobes stay low.
- R7: The address rises by 1 when `mode_i[0]`=0 (byte) and by 2 when `mode_i[0]`=1 (word). `mode_i[5]` (direction) has no effect.
- R8: With `wrap_i` high, the step is added to address bits 23:0 modulo 2^24 and bits 31:24 are kept. With `wrap_i` low, the step is added to all 32 bits.
- R9: On a byte step, the temporary register becomes {data_i[7:0], previous bits 15:8}. On a word step it becomes data_i[15:0].
- R10: A step while inactive changes neither count, address nor any pulse output. A count load sets `active_o` and clears `tc_o`. A load takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_load_i | input | 1 | Load count and start channel |
| cnt_val_i | input | 16 | Count value to load |
| addr_load_i | input | 1 | Load address |
| addr_val_i | input | 32 | Address value to load |
| mode_i | input | 8 | Channel mode byte: [7:6] transfer type, [5] direction (ignored), [0] word |
| wrap_i | input | 1 | Confine address carries to bits 23:0 |
| step_i | input | 1 | One transfer completed |
| data_i | input | 16 | Data moved by this transfer |
| dreq_i | input | 1 | Live request line of the channel |
| end_req_i | input | 1 | External end-of-transfer request |
| cnt_o | output | 16 | Current count |
| addr_o | output | 32 | Current address |
| tmp_o | output | 16 | Temporary data register |
| active_o | output | 1 | Channel running |
| tc_o | output | 1 | Terminal count reached |
| done_o | output | 1 | Channel ended (pulse) |
| ack_o | output | 1 | End acknowledge (pulse) |
| clr_req_o | output | 1 | Clear request bit (pulse) |
| clr_sreq_o | output | 1 | Clear software-request bit (pulse) |

## Verification
The assertions assume that `mode_i`, `wrap_i`, `dreq_i` and `end_req_i` are stable across the edge on which `step_i` is sampled. They also assume that `step_i` is a single-cycle pulse. The bench honours both assumptions: it changes inputs only on falling edges and raises `step_i` for exactly one cycle. It keeps loads and steps in separate cycles, except when checking load priority. Because of this, each step's effect can be read at the following falling edge without overlap.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  localparam int unsigned MODE_WORD_BIT = 0;
  localparam int unsigned MODE_XM_LSB   = 6;

  function automatic xfer_mode_e mode_decode(input logic [7:0] mode);
    return xfer_mode_e'(mode[MODE_XM_LSB +: 2]);
  endfunction
endpackage

// File: rtl/dmaseq_count.sv
module dmaseq_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // underflow happens on the step taken at zero
  assign uflow_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dmaseq_addr.sv
module dmaseq_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WRAP_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  input  logic              word_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_full, addr_next;
  logic [ADDR_W-1:0] step_amt;

  assign step_amt  = word_i ? ADDR_W'(2) : ADDR_W'(1);
  assign addr_full = addr_q + step_amt;

  generate
    if (WRAP_W < ADDR_W) begin : g_wrap
      logic [WRAP_W-1:0] low_next;
      assign low_next  = addr_q[WRAP_W-1:0] + step_amt[WRAP_W-1:0];
      assign addr_next = wrap_i ? {addr_q[ADDR_W-1:WRAP_W], low_next} : addr_full;
    end else begin : g_nowrap
      assign addr_next = addr_full;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (adv_i)  addr_q <= addr_next;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dmaseq_tmp.sv
module dmaseq_tmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] tmp_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] tmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmp_q <= '0;
    else if (cap_i)  tmp_q <= word_i ? data_i : {data_i[HALF-1:0], tmp_q[DATA_W-1:HALF]};
  end

  assign tmp_o = tmp_q;
endmodule

// File: rtl/dmaseq_term.sv
module dmaseq_term
  import dmaseq_pkg::*;
(
  input  xfer_mode_e xm_i,
  input  logic       uflow_i,
  input  logic       end_req_i,
  input  logic       dreq_i,
  output logic       end_o,
  output logic       tc_o,
  output logic       ack_o,
  output logic       clr_o
);
  logic single;

  assign single = (xm_i == XM_SINGLE);

  always_comb begin
    end_o = 1'b0;
    tc_o  = 1'b0;
    ack_o = 1'b0;
    if (uflow_i) begin
      end_o = 1'b1;
      tc_o  = 1'b1;
      ack_o = 1'b1;
    end else if (!single && end_req_i) begin
      end_o = 1'b1;
      ack_o = 1'b1;
    end else if (xm_i == XM_DEMAND && !dreq_i) begin
      end_o = 1'b1;
    end
  end

  assign clr_o = single;
endmodule

// File: rtl/dmaseq_chan.sv
module dmaseq_chan
  import dmaseq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WRAP_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_load_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic [7:0]        mode_i,
  input  logic              wrap_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dreq_i,
  input  logic              end_req_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] tmp_o,
  output logic              active_o,
  output logic              tc_o,
  output logic              done_o,
  output logic              ack_o,
  output logic              clr_req_o,
  output logic              clr_sreq_o
);
  logic       active_q, tc_q, done_q, ack_q, clr_q;
  logic       adv, uflow, word;
  logic       t_end, t_tc, t_ack, t_clr;
  xfer_mode_e xm;

  assign xm   = mode_decode(mode_i);
  assign word = mode_i[MODE_WORD_BIT];
  // loads win over a coincident step
  assign adv  = step_i & active_q & ~cnt_load_i & ~addr_load_i;

  dmaseq_count #(.CNT_W(CNT_W)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load_i),
    .load_val_i (cnt_val_i),
    .dec_i      (adv),
    .cnt_o      (cnt_o),
    .uflow_o    (uflow)
  );

  dmaseq_addr #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) i_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load_i),
    .load_val_i (addr_val_i),
    .adv_i      (adv),
    .word_i     (word),
    .wrap_i     (wrap_i),
    .addr_o     (addr_o)
  );

  dmaseq_tmp #(.DATA_W(DATA_W)) i_tmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (adv),
    .word_i (word),
    .data_i (data_i),
    .tmp_o  (tmp_o)
  );

  dmaseq_term i_term (
    .xm_i      (xm),
    .uflow_i   (uflow),
    .end_req_i (end_req_i),
    .dreq_i    (dreq_i),
    .end_o     (t_end),
    .tc_o      (t_tc),
    .ack_o     (t_ack),
    .clr_o     (t_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tc_q     <= 1'b0;
      done_q   <= 1'b0;
      ack_q    <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      done_q <= adv & t_end;
      ack_q  <= adv & t_ack;
      clr_q  <= adv & t_clr;
      if (cnt_load_i) begin
        active_q <= 1'b1;
        tc_q     <= 1'b0;
      end else if (adv) begin
        if (t_end) active_q <= 1'b0;
        if (t_tc)  tc_q     <= 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign tc_o       = tc_q;
  assign done_o     = done_q;
  assign ack_o      = ack_q;
  assign clr_req_o  = clr_q;
  assign clr_sreq_o = clr_q;
endmodule

// File: rtl/dmaseq_chan_chk.sv
module dmaseq_chan_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WRAP_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_load_i,
  input logic [CNT_W-1:0]  cnt_val_i,
  input logic              addr_load_i,
  input logic [ADDR_W-1:0] addr_val_i,
  input logic [7:0]        mode_i,
  input logic              wrap_i,
  input logic              step_i,
  input logic [DATA_W-1:0] data_i,
  input logic              dreq_i,
  input logic              end_req_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] tmp_o,
  input logic              active_o,
  input logic              tc_o,
  input logic              done_o,
  input logic              ack_o,
  input logic              clr_req_o,
  input logic              clr_sreq_o
);
  logic adv_seen;
  assign adv_seen = step_i && active_o && !cnt_load_i && !addr_load_i;

  assert_cnt_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_seen |=> cnt_o == CNT_W'($past(cnt_o) - CNT_W'(1)));

  assert_tc_uflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> $past(adv_seen && cnt_o == '0));

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(cnt_load_i)) |-> !active_o);

  assert_ack_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> done_o);

  assert_clr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o |-> ($past(mode_i[7:6]) == 2'b01 && clr_sreq_o));

  assert_wrap_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_seen && wrap_i) |=> addr_o[ADDR_W-1:WRAP_W] == $past(addr_o[ADDR_W-1:WRAP_W]));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !active_o && !cnt_load_i && !addr_load_i) |=>
      ($stable(cnt_o) && $stable(addr_o) && !done_o && !clr_req_o));
endmodule

bind dmaseq_chan dmaseq_chan_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .DATA_W(DATA_W)
) i_chk (.*);

// File: tb/test_dmaseq_chan.sv
module test_dmaseq_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_load_i = 1'b0;
  logic [15:0] cnt_val_i = '0;
  logic        addr_load_i = 1'b0;
  logic [31:0] addr_val_i = '0;
  logic [7:0]  mode_i = '0;
  logic        wrap_i = 1'b0;
  logic        step_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        dreq_i = 1'b1;
  logic        end_req_i = 1'b0;
  logic [15:0] cnt_o;
  logic [31:0] addr_o;
  logic [15:0] tmp_o;
  logic        active_o, tc_o, done_o, ack_o, clr_req_o, clr_sreq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  dmaseq_chan i_dmaseq_chan (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] c, input logic [31:0] a);
    @(negedge clk_i);
    cnt_load_i = 1'b1; cnt_val_i = c;
    addr_load_i = 1'b1; addr_val_i = a;
    @(negedge clk_i);
    cnt_load_i = 1'b0; addr_load_i = 1'b0;
  endtask

  task automatic step(input logic [15:0] d);
    @(negedge clk_i);
    step_i = 1'b1; data_i = d;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cnt", cnt_o, 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 tmp", tmp_o, 0);
    chk("R1 flags", {active_o, tc_o, done_o, ack_o, clr_req_o, clr_sreq_o}, 0);
  endtask

  task automatic t_block_tc;
    mode_i = 8'h80; wrap_i = 1'b0; end_req_i = 1'b0;
    load(16'd2, 32'h100);
    chk("R10 active after load", active_o, 1);
    step(16'h0011);
    chk("R2 cnt 1", cnt_o, 1);
    chk("R7 addr byte", addr_o, 32'h101);
    step(16'h0022);
    chk("R2 cnt 0", cnt_o, 0);
    chk("R2 still active", {active_o, done_o}, 2'b10);
    step(16'h0033);
    chk("R3 cnt ffff", cnt_o, 16'hffff);
    chk("R3 tc/done/ack/active", {tc_o, done_o, ack_o, active_o}, 4'b1110);
    chk("R6 no clr in block", {clr_req_o, clr_sreq_o}, 0);
    @(negedge clk_i);
    chk("R3 pulses one cycle", {done_o, ack_o, tc_o}, 3'b001);
    step(16'h0044);
    chk("R10 idle cnt", cnt_o, 16'hffff);
    chk("R10 idle addr", addr_o, 32'h103);
    chk("R10 idle pulses", {done_o, ack_o}, 0);
    load(16'd7, 32'h0);
    chk("R10 load clears tc", {tc_o, active_o}, 2'b01);
  endtask

  task automatic t_word_tmp;
    mode_i = 8'hA1;
    load(16'd5, 32'h200);
    step(16'h1234);
    chk("R7 word step, dir ignored", addr_o, 32'h202);
    chk("R9 word tmp", tmp_o, 16'h1234);
    mode_i = 8'hA0;
    step(16'h99AB);
    chk("R7 byte step, dir ignored", addr_o, 32'h203);
    chk("R9 byte tmp 1", tmp_o, 16'hAB12);
    step(16'h00CD);
    chk("R9 byte tmp 2", tmp_o, 16'hCDAB);
  endtask

  task automatic t_wrap;
    mode_i = 8'h80; wrap_i = 1'b1;
    load(16'd5, 32'h12FF_FFFF);
    step(16'h0);
    chk("R8 wrap byte", addr_o, 32'h1200_0000);
    mode_i = 8'h81;
    load(16'd5, 32'h12FF_FFFF);
    step(16'h0);
    chk("R8 wrap word", addr_o, 32'h1200_0001);
    wrap_i = 1'b0; mode_i = 8'h80;
    load(16'd5, 32'h12FF_FFFF);
    step(16'h0);
    chk("R8 no wrap carry", addr_o, 32'h1300_0000);
  endtask

  task automatic t_end_req;
    mode_i = 8'h80; end_req_i = 1'b1;
    load(16'd5, 32'h0);
    step(16'h0);
    chk("R4 block end req", {done_o, ack_o, tc_o, active_o}, 4'b1100);
    chk("R4 cnt", cnt_o, 4);
    mode_i = 8'h40;
    load(16'd3, 32'h0);
    step(16'h0);
    chk("R6 single end req ignored", {active_o, done_o, tc_o}, 3'b100);
    chk("R6 single clears", {clr_req_o, clr_sreq_o}, 2'b11);
    @(negedge clk_i);
    chk("R6 clear pulse width", {clr_req_o, clr_sreq_o}, 0);
    end_req_i = 1'b0;
    load(16'd0, 32'h0);
    step(16'h0);
    chk("R6 single tc", {tc_o, done_o, ack_o, clr_req_o, clr_sreq_o, active_o}, 6'b111110);
  endtask

  task automatic t_demand;
    mode_i = 8'h00; dreq_i = 1'b1;
    load(16'd5, 32'h0);
    step(16'h0);
    chk("R5 demand continue", {active_o, done_o}, 2'b10);
    dreq_i = 1'b0;
    step(16'h0);
    chk("R5 demand stop", {done_o, ack_o, tc_o, active_o}, 4'b1000);
    dreq_i = 1'b1;
  endtask

  task automatic t_load_prio;
    mode_i = 8'h80;
    load(16'd9, 32'h40);
    @(negedge clk_i);
    step_i = 1'b1; cnt_load_i = 1'b1; cnt_val_i = 16'd20;
    @(negedge clk_i);
    step_i = 1'b0; cnt_load_i = 1'b0;
    chk("R10 load over step cnt", cnt_o, 20);
    chk("R10 load over step addr", addr_o, 32'h40);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_block_tc();
    t_word_tmp();
    t_wrap();
    t_end_req();
    t_demand();
    t_load_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule